// File: doc/BRIEF.md
# Three-Wire Serial Memory Command Front End

This block is the slave side of a three-wire serial memory port with a chip select, a serial clock, a data input and a data output. A frame starts once select is high. Zeros on the data line are skipped until the first one is sampled on a rising serial clock edge. That one is the start bit. Two opcode bits follow, then an address of parameterised width sent most significant bit first. For write-type frames a data word follows the address. The select and serial lines are taken in through a synchroniser and sampled by the system clock.

Every command other than a read is decoded and handed on as a one-cycle command pulse to a separate programming controller. The pulse carries the opcode, the opcode extension, the address and the data word. Reads are served inside the block. It drives a memory read port, sends a single leading zero and then the addressed word on the output line. It keeps streaming the following words with no gap for as long as select stays high. The word organisation (8 or 16 bits) is chosen by a parameter, and the address width follows from it.

Top module: `ew_front`

## Requirements
- R1: After reset the output enable is low and no command pulse is raised.
- R2: While select is high and no frame has begun, zeros sampled on rising serial clock edges are ignored; the first one sampled is the start bit.
- R3: The two bits after the start bit are the opcode (read 10, write 01, erase 11, group 00). For group 00 the two top address bits give the extension (disable 00, write-all 01, erase-all 10, enable 11), reported on the extension output. For the other opcodes the extension output is 00.
- R4: The address is ADDR_X16_BITS bits wide in 16-bit mode, one bit wider in 8-bit mode, and is sent MSB first. Erase, disable, erase-all and enable raise a one-cycle command pulse once the last address bit is taken, with data 0.
- R5: Write and write-all take a data word (16 or 8 bits) MSB first after the address. The command pulse carries that word and is raised after its last bit.
- R6: For a read, the rising serial clock edge that takes the last address bit raises the output enable and drives a 0. Each later rising edge drives the next bit of the addressed word, MSB first.
- R7: After the last bit of a read word, the address steps by one and the next word follows on the next rising edge, with no leading zero.
- R8: A sequential read wraps from the highest address to address 0.
- R9: Select low drops the output enable, discards a partial frame without a command pulse, and makes the next frame wait for a new start bit.
- R10: A read frame never raises a command pulse.
- R11: After a command pulse, further serial clock edges are ignored until select goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select, high for a frame |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (low means high impedance) |
| mem_rd_addr_o | output | AW | Memory read address |
| mem_rd_data_i | input | DW | Memory read data, one clock after the address |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_op_o | output | 2 | Opcode of the command |
| cmd_ext_o | output | 2 | Opcode extension for group 00, else 00 |
| cmd_addr_o | output | AW | Address of the command |
| cmd_data_o | output | DW | Data word for write and write-all, else 0 |

## Verification
A bit counter off by one shows up as a misplaced address or data bit in the command fields, or as a word at the output that is shifted one place. Either is visible at the first command pulse or the first read word after the fault. If the frame state is not cleared when select drops, the next frame decodes the wrong opcode or raises an extra pulse. This shows within that one frame. A wrong address step after a read word shows in the second word streamed out, and the wrap case shows it at the highest address.

// File: rtl/ew_pkg.sv
package ew_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } ew_state_e;

    localparam logic [1:0] OP_GRP   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_DIS  = 2'b00;
    localparam logic [1:0] EXT_WRAL = 2'b01;
    localparam logic [1:0] EXT_ERAL = 2'b10;
    localparam logic [1:0] EXT_EN   = 2'b11;
endpackage

// File: rtl/ew_sync.sv
module ew_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] s_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[g] <= '0;
            end else if (g == 0) begin
                stg_q[g] <= a_i;
            end else begin
                stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign s_o = stg_q[STAGES-1];
endmodule

// File: rtl/ew_shift_in.sv
module ew_shift_in #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         din_i,
    output logic [W-1:0] val_o,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] sh_d, sh_q;

    assign nxt_o = {sh_q[W-2:0], din_i};

    always_comb begin
        sh_d = sh_q;
        if (clr_i) begin
            sh_d = '0;
        end else if (en_i) begin
            sh_d = nxt_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign val_o = sh_q;
endmodule

// File: rtl/ew_front.sv
module ew_front
    import ew_pkg::*;
#(
    parameter int ADDR_X16_BITS = 6,
    parameter bit ORG_X16       = 1'b1,
    parameter int SYNC_STAGES   = 2,
    localparam int AW = ADDR_X16_BITS + (ORG_X16 ? 0 : 1),
    localparam int DW = ORG_X16 ? 16 : 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          sck_i,
    input  logic          sdi_i,
    output logic          sdo_o,
    output logic          sdo_oe_o,
    output logic [AW-1:0] mem_rd_addr_o,
    input  logic [DW-1:0] mem_rd_data_i,
    output logic          cmd_valid_o,
    output logic [1:0]    cmd_op_o,
    output logic [1:0]    cmd_ext_o,
    output logic [AW-1:0] cmd_addr_o,
    output logic [DW-1:0] cmd_data_o
);
    localparam int SW = (AW > DW) ? AW : DW;
    localparam int CW = $clog2(SW + 1);

    typedef struct packed {
        ew_state_e     st;
        logic [CW-1:0] cnt;
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic          q;
        logic          oe;
        logic          sck_prev;
        logic          cmd_valid;
        logic [1:0]    cmd_op;
        logic [1:0]    cmd_ext;
        logic [AW-1:0] cmd_addr;
        logic [DW-1:0] cmd_data;
    } front_t;

    front_t r_d, r_q;

    logic [2:0]    sync_s;
    logic          sel_s, sck_s, sdi_s;
    logic          sck_rise;
    logic          sh_clr, sh_en;
    logic [SW-1:0] sh_val, sh_nxt;
    logic [1:0]    ext;
    logic [DW-1:0] rd_word;

    ew_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   ({sel_i, sck_i, sdi_i}),
        .s_o   (sync_s)
    );

    assign sel_s = sync_s[2];
    assign sck_s = sync_s[1];
    assign sdi_s = sync_s[0];
    assign sck_rise = sck_s & ~r_q.sck_prev;

    ew_shift_in #(.W(SW)) i_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (sh_clr),
        .en_i  (sh_en),
        .din_i (sdi_s),
        .val_o (sh_val),
        .nxt_o (sh_nxt)
    );

    assign ext     = sh_nxt[AW-1 -: 2];
    assign rd_word = mem_rd_data_i << r_q.cnt;

    always_comb begin
        r_d           = r_q;
        r_d.cmd_valid = 1'b0;
        r_d.sck_prev  = sck_s;
        sh_clr        = 1'b0;
        sh_en         = 1'b0;

        if (!sel_s) begin
            r_d.st  = ST_IDLE;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else if (sck_rise) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (sdi_s) begin
                        r_d.st  = ST_OPC;
                        r_d.cnt = '0;
                        sh_clr  = 1'b1;
                    end
                end
                ST_OPC: begin
                    r_d.op = {r_q.op[0], sdi_s};
                    if (r_q.cnt == CW'(1)) begin
                        r_d.st  = ST_ADDR;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                ST_ADDR: begin
                    sh_en = 1'b1;
                    if (r_q.cnt == CW'(AW-1)) begin
                        r_d.addr = sh_nxt[AW-1:0];
                        r_d.cnt  = '0;
                        if (r_q.op == OP_READ) begin
                            r_d.st = ST_READ;
                            r_d.q  = 1'b0;
                            r_d.oe = 1'b1;
                        end else if (r_q.op == OP_WRITE ||
                                     (r_q.op == OP_GRP && ext == EXT_WRAL)) begin
                            r_d.st = ST_DATA;
                        end else begin
                            r_d.st        = ST_DONE;
                            r_d.cmd_valid = 1'b1;
                            r_d.cmd_op    = r_q.op;
                            r_d.cmd_ext   = (r_q.op == OP_GRP) ? ext : 2'b00;
                            r_d.cmd_addr  = sh_nxt[AW-1:0];
                            r_d.cmd_data  = '0;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                ST_DATA: begin
                    sh_en = 1'b1;
                    if (r_q.cnt == CW'(DW-1)) begin
                        r_d.st        = ST_DONE;
                        r_d.cmd_valid = 1'b1;
                        r_d.cmd_op    = r_q.op;
                        r_d.cmd_ext   = (r_q.op == OP_GRP) ? r_q.addr[AW-1 -: 2] : 2'b00;
                        r_d.cmd_addr  = r_q.addr;
                        r_d.cmd_data  = sh_nxt[DW-1:0];
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                ST_READ: begin
                    r_d.q = rd_word[DW-1];
                    if (r_q.cnt == CW'(DW-1)) begin
                        r_d.cnt  = '0;
                        r_d.addr = r_q.addr + AW'(1);
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo_o         = r_q.q;
    assign sdo_oe_o      = r_q.oe;
    assign mem_rd_addr_o = r_q.addr;
    assign cmd_valid_o   = r_q.cmd_valid;
    assign cmd_op_o      = r_q.cmd_op;
    assign cmd_ext_o     = r_q.cmd_ext;
    assign cmd_addr_o    = r_q.cmd_addr;
    assign cmd_data_o    = r_q.cmd_data;

    logic unused_sh;
    assign unused_sh = ^sh_val;
endmodule

// File: rtl/ew_front_chk.sv
module ew_front_chk #(
    parameter int ADDR_X16_BITS = 6,
    parameter bit ORG_X16       = 1'b1,
    localparam int AW = ADDR_X16_BITS + (ORG_X16 ? 0 : 1),
    localparam int DW = ORG_X16 ? 16 : 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_s,
    input logic          sck_rise,
    input logic          sdo_o,
    input logic          sdo_oe_o,
    input logic          cmd_valid_o,
    input logic [1:0]    cmd_op_o,
    input logic [1:0]    cmd_ext_o,
    input logic [AW-1:0] cmd_addr_o,
    input logic [DW-1:0] cmd_data_o
);
    assert_oe_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> !sdo_oe_o);

    assert_cmd_needs_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> sel_s);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    assert_fields_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_o |-> ($stable(cmd_addr_o) && $stable(cmd_data_o) && $stable(cmd_op_o)));

    assert_ext_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o != 2'b00) |-> cmd_ext_o == 2'b00);

    assert_no_read_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_op_o != 2'b10);

    assert_q_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise |=> $stable(sdo_o));
endmodule

bind ew_front ew_front_chk #(.ADDR_X16_BITS(ADDR_X16_BITS), .ORG_X16(ORG_X16)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_s       (sel_s),
    .sck_rise    (sck_rise),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (cmd_op_o),
    .cmd_ext_o   (cmd_ext_o),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_data_o  (cmd_data_o)
);

// File: tb/test_ew_front.sv
`timescale 1ns/1ps
module test_ew_front;
    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic          sdo, sdo_oe;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data = '0;
    logic          cmd_valid;
    logic [1:0]    cmd_op, cmd_ext;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    logic [1:0]    got_op, got_ext;
    logic [AW-1:0] got_addr;
    logic [DW-1:0] got_data;

    always #4 clk = ~clk;

    ew_front i_ew_front (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .sck_i(sck), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data),
        .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_ext_o(cmd_ext),
        .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
    );

    function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
        return {a, ~a, 4'h9};
    endfunction

    always @(posedge clk) rd_data <= mem_f(rd_addr);

    always @(posedge clk) begin
        if (cmd_valid) begin
            pulses   <= pulses + 1;
            got_op   <= cmd_op;
            got_ext  <= cmd_ext;
            got_addr <= cmd_addr;
            got_data <= cmd_data;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        sck = 1'b0;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_bit(output logic b);
        sck = 1'b0;
        repeat (4) @(negedge clk);
        b = sdo;
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_addr(input logic [AW-1:0] a);
        for (int i = AW-1; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic deselect();
        sck = 1'b0;
        sel = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic read_word(output logic [DW-1:0] w);
        logic b;
        for (int i = DW-1; i >= 0; i--) begin
            read_bit(b);
            w[i] = b;
        end
    endtask

    // entry: op(2) addr(6) data(16) ext(2) has_data(1)
    localparam int NV = 6;
    localparam logic [26:0] VEC [NV] = '{
        {2'b01, 6'h05, 16'hA55A, 2'b00, 1'b1},
        {2'b11, 6'h3F, 16'h0000, 2'b00, 1'b0},
        {2'b00, 6'h30, 16'h0000, 2'b11, 1'b0},
        {2'b00, 6'h00, 16'h0000, 2'b00, 1'b0},
        {2'b00, 6'h20, 16'h0000, 2'b10, 1'b0},
        {2'b00, 6'h10, 16'h0F0F, 2'b01, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] w;
        logic b;
        int p0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sdo_oe == 1'b0, "R1 oe after reset", 32'(sdo_oe), 0);
        check(cmd_valid == 1'b0 && pulses == 0, "R1 no pulse after reset", 32'(pulses), 0);

        // Vector walk: R2 R3 R4 R5 R11
        for (int v = 0; v < NV; v++) begin
            logic [1:0]    op;
            logic [AW-1:0] ad;
            logic [DW-1:0] dt;
            logic [1:0]    ex;
            logic          hd;
            {op, ad, dt, ex, hd} = VEC[v];
            p0 = pulses;
            sel = 1'b1;
            repeat (4) @(negedge clk);
            send_bit(1'b0);
            send_bit(1'b0);
            send_bit(1'b1);
            send_bit(op[1]);
            send_bit(op[0]);
            send_addr(ad);
            if (hd) for (int i = DW-1; i >= 0; i--) send_bit(dt[i]);
            send_bit(1'b1);
            send_bit(1'b1);
            deselect();
            check(pulses == p0 + 1, "R11 R4 R5 exactly one pulse", 32'(pulses - p0), 1);
            check(got_op == op, "R3 opcode", 32'(got_op), 32'(op));
            check(got_ext == ex, "R3 extension", 32'(got_ext), 32'(ex));
            check(got_addr == ad, "R4 address", 32'(got_addr), 32'(ad));
            check(got_data == (hd ? dt : '0), "R5 data word", 32'(got_data), 32'(hd ? dt : '0));
        end

        // R6 R7 R2 R10: read with leading zeros, two words
        p0 = pulses;
        sel = 1'b1;
        repeat (4) @(negedge clk);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        send_addr(6'h12);
        read_bit(b);
        check(sdo_oe == 1'b1, "R6 oe during read", 32'(sdo_oe), 1);
        check(b == 1'b0, "R6 leading zero", 32'(b), 0);
        read_word(w);
        check(w == mem_f(6'h12), "R6 first word", 32'(w), 32'(mem_f(6'h12)));
        read_word(w);
        check(w == mem_f(6'h13), "R7 next word no gap", 32'(w), 32'(mem_f(6'h13)));
        deselect();
        check(pulses == p0, "R10 read raises no pulse", 32'(pulses - p0), 0);
        check(sdo_oe == 1'b0, "R9 oe low after deselect", 32'(sdo_oe), 0);

        // R8: wrap at the top address
        sel = 1'b1;
        repeat (4) @(negedge clk);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        send_addr(6'h3F);
        read_bit(b);
        read_word(w);
        check(w == mem_f(6'h3F), "R8 top word", 32'(w), 32'(mem_f(6'h3F)));
        read_word(w);
        check(w == mem_f(6'h00), "R8 wrap to zero", 32'(w), 32'(mem_f(6'h00)));
        deselect();

        // R9: aborted read then aborted write, then a full erase
        sel = 1'b1;
        repeat (4) @(negedge clk);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        send_addr(6'h04);
        read_bit(b);
        for (int i = 0; i < 5; i++) read_bit(b);
        deselect();
        check(sdo_oe == 1'b0, "R9 oe low mid-read", 32'(sdo_oe), 0);
        p0 = pulses;
        sel = 1'b1;
        repeat (4) @(negedge clk);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        deselect();
        check(pulses == p0, "R9 partial frame discarded", 32'(pulses - p0), 0);
        sel = 1'b1;
        repeat (4) @(negedge clk);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        send_addr(6'h2A);
        deselect();
        check(pulses == p0 + 1, "R9 new frame one pulse", 32'(pulses - p0), 1);
        check(got_op == 2'b11 && got_addr == 6'h2A, "R9 new frame decoded",
              32'({got_op, got_addr}), 32'({2'b11, 6'h2A}));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule